// File: doc/BRIEF.md
# Low-Order Interleaved Bank Controller

This block sits between a processor word port and a set of NBANK independent synchronous memory banks. Word addresses are spread so that the bank holding a word is the word address modulo NBANK (NBANK is a power of two), and the remaining upper address bits give the row inside that bank. Consecutive words therefore land in different banks, and an aligned group of NBANK consecutive words can be reached in one parallel access, with every bank working at the same time.

A read request names any address. The controller presents that address's row to every bank at once. After the bank latency it hands the group back one word per clock, lowest address first. Writes arrive one word at a time. They are gathered into a group buffer and scattered to all banks in a single parallel write only once every word of an aligned group is present. One `busy` output covers bank occupancy, a pending group write and a read burst still being sent. Any request made while it is high is dropped.

Top module: `ilv_bank_ctrl`

## Requirements
- R1: A word at address a is stored in bank (a mod NBANK), which is the low log2(NBANK) address bits, at row (a / NBANK), which is the upper address bits.
- R2: An accepted read delivers NBANK words on consecutive cycles with `out_valid` high. They come in increasing address order: bank 0 of the group first, bank NBANK-1 last.
- R3: The first word of a read appears LAT cycles after the clock edge that accepted the request.
- R4: A read at an address that is not group aligned returns the whole aligned group that contains it, starting from the group base.
- R5: `busy` is high from the accepting edge of a read until the last-but-one word of its burst is presented. A read request or write word presented while `busy` is high is ignored.
- R6: Write words may arrive in any bank order. Banks are written only when all NBANK words of one row have been collected, and then all banks are written together.
- R7: A partial group never changes memory. A write word for a different row than the partial group discards the partial group and starts a new one.
- R8: A second write word for a bank already held in the current group replaces the held word.
- R9: After the edge that completes a write group, `busy` stays high for LAT+1 cycles (one cycle pending, then LAT cycles of bank occupancy).
- R10: When a read request and a write word arrive in the same free cycle, the read is taken and the write word is dropped.
- R11: After reset, `busy` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read group request |
| rd_addr | input | AW | Word address of the read (any word of the group) |
| wr_valid | input | 1 | Write word present |
| wr_addr | input | AW | Word address of the write word |
| wr_data | input | DW | Write word data |
| busy | output | 1 | Requests are refused while high |
| out_valid | output | 1 | Read word present on out_data |
| out_data | output | DW | Read word, group base first |

## Verification
Write groups are supplied in ascending bank order and in scrambled order. A repeated bank is also used, and these cases separate correct bank/row decoding from simple arrival-order storage. Partial groups that are followed by a different row show whether uncommitted words leak into memory. A simultaneous read-and-write cycle shows whether the dropped write word shifts the commit point, which becomes visible in the `busy` profile. Unaligned single reads, requests repeated while busy, and a continuously held read request with a changing address check ordering, latency and refusal. A reference model compares `busy`, `out_valid` and `out_data` on every cycle.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // bank index of a word address (nbank is a power of two)
  function automatic int bank_of(int addr, int nbank);
    return addr & (nbank - 1);
  endfunction

  // row inside a bank for a word address
  function automatic int row_of(int addr, int nbank);
    return addr / nbank;
  endfunction
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DW  = 16,
  parameter int RW  = 6,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << RW;

  logic [DW-1:0] mem [DEPTH];
  logic [LAT-1:0] v_q;
  logic [LAT-1:0] w_q;
  logic [DW-1:0]  d_q [LAT];

  always_ff @(posedge clk) begin
    if (en && we) mem[row] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      w_q    <= '0;
      d_q[0] <= '0;
    end else begin
      v_q[0] <= en;
      w_q[0] <= we;
      d_q[0] <= mem[row];
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
        w_q[s] <= 1'b0;
        d_q[s] <= '0;
      end else begin
        v_q[s] <= v_q[s-1];
        w_q[s] <= w_q[s-1];
        d_q[s] <= d_q[s-1];
      end
    end
  end

  assign busy   = |v_q;
  assign rvalid = v_q[LAT-1] & ~w_q[LAT-1];
  assign rdata  = d_q[LAT-1];
endmodule

// File: rtl/ilv_wr_gather.sv
module ilv_wr_gather #(
  parameter int NBANK = 4,
  parameter int DW    = 16,
  parameter int RW    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic [$clog2(NBANK)-1:0]   bank,
  input  logic [RW-1:0]              row,
  input  logic [DW-1:0]              wdata,
  input  logic                       commit,
  output logic                       full,
  output logic [RW-1:0]              g_row,
  output logic [NBANK-1:0][DW-1:0]   g_data,
  output logic [NBANK-1:0]           wen
);
  logic [NBANK-1:0] mask;
  logic [NBANK-1:0] hit;

  assign hit = NBANK'(1) << bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      g_row  <= '0;
      g_data <= '0;
    end else if (commit) begin
      mask <= '0;
    end else if (take) begin
      // a word for another row drops the partial group
      if (mask != '0 && row != g_row) mask <= hit;
      else                            mask <= mask | hit;
      g_row        <= row;
      g_data[bank] <= wdata;
    end
  end

  assign full = &mask;
  assign wen  = {NBANK{commit}} & mask;
endmodule

// File: rtl/ilv_rd_serial.sv
module ilv_rd_serial #(
  parameter int NBANK = 4,
  parameter int DW    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NBANK-1:0][DW-1:0]  words,
  output logic                      out_valid,
  output logic [DW-1:0]             out_data,
  output logic                      more
);
  localparam int BW = $clog2(NBANK);
  localparam int CW = $clog2(NBANK + 1);

  logic [NBANK-1:0][DW-1:0] hold;
  logic [CW-1:0]            left;
  logic [BW-1:0]            idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      left      <= '0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      hold      <= words;
      out_data  <= words[0];
      idx       <= BW'(1);
      left      <= CW'(NBANK - 1);
      out_valid <= 1'b1;
    end else if (left != '0) begin
      out_data  <= hold[idx];
      idx       <= idx + 1'b1;
      left      <= left - 1'b1;
      out_valid <= 1'b1;
    end else begin
      out_valid <= 1'b0;
    end
  end

  assign more = (left != '0);
endmodule

// File: rtl/ilv_bank_ctrl.sv
module ilv_bank_ctrl #(
  parameter int NBANK = 4,
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int LAT   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int BW = $clog2(NBANK);
  localparam int RW = AW - BW;

  logic [RW-1:0]            rd_row, wr_row, bk_row;
  logic [BW-1:0]            wr_bank;
  logic                     rd_take, wr_take, commit;
  logic                     g_full, s_more, bank_busy_any, grp_ready;
  logic [RW-1:0]            g_row;
  logic [NBANK-1:0][DW-1:0] g_data;
  logic [NBANK-1:0][DW-1:0] rd_words;
  logic [NBANK-1:0]         g_wen, bank_en, bbusy, brvalid;

  assign rd_row  = RW'(ilv_pkg::row_of(int'(rd_addr), NBANK));
  assign wr_row  = RW'(ilv_pkg::row_of(int'(wr_addr), NBANK));
  assign wr_bank = BW'(ilv_pkg::bank_of(int'(wr_addr), NBANK));

  assign bank_busy_any = |bbusy;
  assign busy          = bank_busy_any | s_more | g_full;
  assign rd_take       = rd_req & ~busy;
  assign wr_take       = wr_valid & ~busy & ~rd_req;
  assign commit        = g_full & ~bank_busy_any;
  assign bk_row        = commit ? g_row : rd_row;
  assign grp_ready     = &brvalid;

  ilv_wr_gather #(.NBANK(NBANK), .DW(DW), .RW(RW)) u_gather (
    .clk(clk), .rst_n(rst_n), .take(wr_take), .bank(wr_bank), .row(wr_row),
    .wdata(wr_data), .commit(commit), .full(g_full), .g_row(g_row),
    .g_data(g_data), .wen(g_wen)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_en[b] = rd_take | g_wen[b];
    ilv_bank #(.DW(DW), .RW(RW), .LAT(LAT)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(bank_en[b]), .we(commit), .row(bk_row),
      .wdata(g_data[b]), .busy(bbusy[b]), .rvalid(brvalid[b]),
      .rdata(rd_words[b])
    );
  end

  ilv_rd_serial #(.NBANK(NBANK), .DW(DW)) u_serial (
    .clk(clk), .rst_n(rst_n), .load(grp_ready), .words(rd_words),
    .out_valid(out_valid), .out_data(out_data), .more(s_more)
  );
endmodule

// File: rtl/ilv_bank_ctrl_chk.sv
module ilv_bank_ctrl_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             full,
  input logic             commit,
  input logic [NBANK-1:0] bank_en,
  input logic [NBANK-1:0] bank_wen,
  input logic [NBANK-1:0] brvalid,
  input logic             out_valid,
  input logic             ser_more
);
  // R6: group write touches every bank together
  p_wen_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_wen) |-> (&bank_wen));

  // R9: a full group is committed on the following edge
  p_commit_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !full);

  // R5: no new bank access while busy, except the group commit
  p_busy_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !full) |-> (bank_en == '0));

  // R2: burst words come on back-to-back cycles
  p_stream_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ser_more) |=> out_valid);

  // R3: all banks return their word in the same cycle
  p_rvalid_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|brvalid) |-> (&brvalid));

  // R7: write enables only on a commit
  p_wen_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_wen) |-> commit);
endmodule

bind ilv_bank_ctrl ilv_bank_ctrl_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .full(g_full), .commit(commit),
  .bank_en(bank_en), .bank_wen(g_wen), .brvalid(brvalid),
  .out_valid(out_valid), .ser_more(s_more)
);

// File: tb/sim_ilv_bank_ctrl.sv
module sim_ilv_bank_ctrl;
  localparam int NB  = 4;
  localparam int DW  = 16;
  localparam int AW  = 8;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 1'b0, wr_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic busy, out_valid;
  logic [DW-1:0] out_data;

  always #5 clk = ~clk;

  ilv_bank_ctrl #(.NBANK(NB), .DW(DW), .AW(AW), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .out_valid(out_valid), .out_data(out_data)
  );

  int nvec = 0, nerr = 0;
  string phase = "R11";

  // reference model state
  int t = 0;
  int busy_until = -1;
  bit exp_busy = 0;
  bit exp_valid = 0;
  logic [DW-1:0] exp_dat = '0;
  int q_time[$];
  logic [DW-1:0] q_data[$];
  logic [DW-1:0] mm [int];
  int g_row = -1;
  bit [NB-1:0] g_mask = '0;
  logic [DW-1:0] g_d [NB];

  always @(posedge clk) begin
    if (!rst_n) begin
      t = 0; busy_until = -1; exp_busy = 0; exp_valid = 0;
      g_mask = '0; q_time.delete(); q_data.delete();
    end else begin
      bit was_busy;
      t++;
      was_busy = exp_busy;
      if (rd_req && !was_busy) begin
        int base;
        base = (int'(rd_addr) / NB) * NB;
        for (int k = 0; k < NB; k++) begin
          q_time.push_back(t + LAT + k);
          q_data.push_back(mm[base + k]);
        end
        busy_until = t + LAT + NB - 2;
      end else if (wr_valid && !was_busy) begin
        int b, r;
        b = int'(wr_addr) % NB;
        r = int'(wr_addr) / NB;
        if (g_mask != '0 && r != g_row) g_mask = '0;
        g_row = r;
        g_mask[b] = 1'b1;
        g_d[b] = wr_data;
        if (&g_mask) begin
          for (int k = 0; k < NB; k++) mm[r*NB + k] = g_d[k];
          g_mask = '0;
          busy_until = t + LAT;
        end
      end
      exp_busy = (t <= busy_until);
      exp_valid = 0;
      if (q_time.size() > 0 && q_time[0] == t) begin
        exp_valid = 1;
        exp_dat = q_data[0];
        void'(q_time.pop_front());
        void'(q_data.pop_front());
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      nvec++;
      if (busy !== exp_busy) begin
        nerr++;
        $display("FAIL %s/R5 busy t=%0d act=%b exp=%b", phase, t, busy, exp_busy);
      end
      nvec++;
      if (out_valid !== exp_valid) begin
        nerr++;
        $display("FAIL %s/R2 out_valid t=%0d act=%b exp=%b", phase, t, out_valid, exp_valid);
      end else if (exp_valid) begin
        nvec++;
        if (out_data !== exp_dat) begin
          nerr++;
          $display("FAIL %s/R1 out_data t=%0d act=%h exp=%h", phase, t, out_data, exp_dat);
        end
      end
    end
  end

  task automatic wait_free();
    while (exp_busy) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wait_free();
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(int a);
    wait_free();
    rd_req = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    idle(3);
    // R11: reset state
    nvec++;
    if (busy !== 1'b0 || out_valid !== 1'b0) begin
      nerr++;
      $display("FAIL R11 reset act=%b%b exp=00", busy, out_valid);
    end
    rst_n = 1'b1;
    idle(2);

    phase = "R6";  // ascending group, row 3
    for (int k = 0; k < NB; k++) wr(12 + k, 16'h3000 + k);
    phase = "R9"; idle(6);
    phase = "R3"; rd(12); idle(8);

    phase = "R6";  // scrambled order, row 5
    wr(21, 16'h5501); wr(23, 16'h5503); wr(20, 16'h5500); wr(22, 16'h5502);
    phase = "R4"; rd(22); idle(8);
    rd(15); idle(8);

    phase = "R7";  // partial row 3 then full row 7
    wr(12, 16'hdead); wr(13, 16'hbeef);
    for (int k = 0; k < NB; k++) wr(28 + k, 16'h7700 + k);
    rd(13); idle(8);
    rd(29); idle(8);

    phase = "R8";  // bank repeated in row 9
    wr(36, 16'h0bad); wr(36, 16'h9900); wr(38, 16'h9902);
    wr(37, 16'h9901); wr(39, 16'h9903);
    rd(37); idle(8);

    phase = "R5";  // requests while busy are dropped
    rd(20);
    rd_req = 1'b1; rd_addr = AW'(28);
    wr_valid = 1'b1; wr_addr = AW'(40); wr_data = 16'h1111;
    idle(3);
    rd_req = 1'b0; wr_valid = 1'b0;
    idle(8);

    phase = "R10"; // read and write word in the same free cycle
    wait_free();
    rd_req = 1'b1; rd_addr = AW'(36);
    wr_valid = 1'b1; wr_addr = AW'(44); wr_data = 16'haaaa;
    @(negedge clk);
    rd_req = 1'b0; wr_valid = 1'b0;
    wr(45, 16'hb001); wr(46, 16'hb002); wr(47, 16'hb003);
    idle(6);
    wr(44, 16'hb000);
    idle(6);
    rd(46); idle(8);

    phase = "R2";  // held read request, changing address
    for (int i = 0; i < 40; i++) begin
      rd_req = 1'b1;
      rd_addr = AW'(((i % 4) == 0) ? 12 : ((i % 4) == 1) ? 21 : ((i % 4) == 2) ? 30 : 45);
      @(negedge clk);
    end
    rd_req = 1'b0;
    idle(10);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule